// File: doc/BRIEF.md
# Byte-Lane Controller for Asynchronous Static RAM

This block connects a synchronous host to an external 16-bit asynchronous static RAM that has one active-low enable per byte. The host issues single-word requests through a valid/ready handshake. Each request carries a word address, a direction flag, write data and two active-high byte-enable bits. Reads return data with a one-clock valid pulse. Writes finish with a one-clock done pulse.

On the memory side the block drives the address, the active-low chip select, output enable, write enable and the two lane enables. It drives the shared data bus through separate output, drive-enable and input signals, so the pad tristate stays outside the block. The length of each access phase is set when the block is built, from the clock period and the memory's timing limits in picoseconds. A phase lasts the ceiling of the slowest applicable limit divided by the clock period, and never less than one clock. The block also inserts a quiet gap after a read before it drives a write, so that the memory's output float time cannot collide with the controller's data.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip select, output enable, write enable and both lane enables are high, the data drive enable is low, `req_ready` is high and neither response pulse is asserted.
- R2: A read holds chip select, output enable and the selected lane enables low for exactly RD_CYC clocks. RD_CYC is the ceiling of the largest of the cycle, address, select, output-enable and byte access times divided by the clock period, with a minimum of one. Data is captured at the edge that ends the phase, and `rsp_rvalid` pulses for one clock starting at that edge, RD_CYC+1 clocks after the accepting edge's preceding half cycle.
- R3: Write enable is high in every cycle in which output enable is low.
- R4: A write holds chip select, write enable and the selected lane enables low together for exactly WR_CYC clocks, with output enable high. WR_CYC is the ceiling of the largest of the write cycle, pulse width, select-to-end and data setup times over the period, with a minimum of one. One hold clock follows with address and data still driven. The drive enable then drops and `rsp_wdone` pulses for one clock.
- R5: While the data drive enable is high, the driven data and the address do not change.
- R6: The data drive enable is never high while output enable is low. After output enable rises at the end of a read, at least TA_CYC clocks pass before the drive enable rises. TA_CYC is the ceiling of the output float time over the period, with a minimum of one.
- R7: Byte-enable bit 0 drives the lower lane enable and covers data bits 7:0. Bit 1 drives the upper lane enable and covers bits 15:8. A write changes only the selected bytes. A read returns zero in every unselected byte.
- R8: A request whose byte enables are both 0 finishes with its response pulse in the cycle after acceptance, and chip select is never asserted. A read of this kind returns zero.
- R9: A request is accepted only while `req_ready` is high. `req_ready` is high only when no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | LANES*LANE_W | Write data |
| req_be | input | LANES | Active-high byte enables, bit 0 = lower byte |
| rsp_rvalid | output | 1 | One-clock read data valid |
| rsp_rdata | output | LANES*LANE_W | Read data, unselected bytes zero |
| rsp_wdone | output | 1 | One-clock write completion |
| mem_addr | output | ADDR_W | Memory word address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_dq_out | output | LANES*LANE_W | Data toward the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | LANES*LANE_W | Data from the memory |

## Verification
The bench builds the block with a 4-bit address and a 4 ns clock, keeping the default timing limits. These give 18-clock read and write phases and an 8-clock turnaround gap, all computed independently in the bench. Sixteen words allow an exhaustive sweep: every address is written under every byte-enable pattern and read back under every pattern. The memory model returns corrupted data until a full read phase has passed, which exposes any early capture. It also checks pulse widths, bus contention and the float gap on every cycle.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_TURN,
      ST_WRITE,
      ST_HOLD
   } ctl_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // whole clocks covering a time in ps, never below one
   function automatic int unsigned phase_clocks(input int unsigned span_ps,
                                                input int unsigned clk_ps);
      int unsigned c;
      c = (span_ps + clk_ps - 1) / clk_ps;
      return (c == 0) ? 1 : c;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expire
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expire = (cnt == '0);
endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
   parameter int unsigned TA_CYC = 1,
   parameter int unsigned CW     = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic drive_ok
);
   logic [CW-1:0] qcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         qcnt <= '0;
      else if (arm)
         qcnt <= CW'(TA_CYC);
      else if (qcnt != '0)
         qcnt <= qcnt - 1'b1;
   end

   // a launch at the next edge lands TA_CYC clocks after the arming edge
   assign drive_ok = (qcnt <= CW'(1));
endmodule

// File: rtl/sram_lane_data.sv
module sram_lane_data #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 2,
   localparam int unsigned DW    = LANE_W * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_load,
   input  logic [DW-1:0]    wr_data,
   input  logic             cap,
   input  logic [LANES-1:0] cap_lanes,
   input  logic [DW-1:0]    dq_in,
   output logic [DW-1:0]    dq_out,
   output logic [DW-1:0]    rd_data
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] out_q;
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= '0;
            rd_q  <= '0;
         end else begin
            if (wr_load)
               out_q <= wr_data[g*LANE_W +: LANE_W];
            if (cap)
               rd_q <= cap_lanes[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
         end
      end

      assign dq_out[g*LANE_W +: LANE_W]  = out_q;
      assign rd_data[g*LANE_W +: LANE_W] = rd_q;
   end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned LANE_W    = 8,
   parameter int unsigned LANES     = 2,
   parameter int unsigned CLK_PS    = 10000,
   parameter int unsigned T_RC_PS   = 70000,
   parameter int unsigned T_AA_PS   = 70000,
   parameter int unsigned T_ACS_PS  = 70000,
   parameter int unsigned T_OE_PS   = 40000,
   parameter int unsigned T_BA_PS   = 40000,
   parameter int unsigned T_WC_PS   = 70000,
   parameter int unsigned T_WP_PS   = 55000,
   parameter int unsigned T_CW_PS   = 60000,
   parameter int unsigned T_DW_PS   = 35000,
   parameter int unsigned T_HZ_PS   = 30000,
   localparam int unsigned DW       = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rsp_rvalid,
   output logic [DW-1:0]     rsp_rdata,
   output logic              rsp_wdone,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_lb_n,
   output logic              mem_ub_n,
   output logic [DW-1:0]     mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DW-1:0]     mem_dq_in
);
   localparam int unsigned RD_CYC = phase_clocks(
      max2(max2(T_RC_PS, T_AA_PS), max2(max2(T_ACS_PS, T_OE_PS), T_BA_PS)), CLK_PS);
   localparam int unsigned WR_CYC = phase_clocks(
      max2(max2(T_WC_PS, T_WP_PS), max2(T_CW_PS, T_DW_PS)), CLK_PS);
   localparam int unsigned TA_CYC = phase_clocks(T_HZ_PS, CLK_PS);
   localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WR_CYC), TA_CYC);
   localparam int unsigned CW = $clog2(MAX_CYC + 2);

   if (LANES != 2) begin : g_bad_lanes
      $error("sram_lane_ctrl: exactly two byte lanes are supported");
   end
   if (CLK_PS == 0) begin : g_bad_clk
      $error("sram_lane_ctrl: clock period must be nonzero");
   end
   if (ADDR_W == 0 || LANE_W == 0) begin : g_bad_width
      $error("sram_lane_ctrl: widths must be nonzero");
   end

   ctl_state_e       state;
   logic [LANES-1:0] pend_be;
   logic [LANES-1:0] lane_n;
   logic             accept, be_any, launch_rd, launch_wr;
   logic             rd_end, wr_end, null_rd;
   logic             tmr_load, tmr_expire, turn_ok;
   logic [CW-1:0]    tmr_val;
   logic [LANES-1:0] cap_lanes;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign be_any    = |req_be;
   assign launch_rd = accept && !req_write && be_any;
   assign launch_wr = (accept && req_write && be_any && turn_ok) ||
                      ((state == ST_TURN) && turn_ok);
   assign rd_end    = (state == ST_READ) && tmr_expire;
   assign wr_end    = (state == ST_WRITE) && tmr_expire;
   assign null_rd   = accept && !req_write && !be_any;
   assign tmr_load  = launch_rd || launch_wr;
   assign tmr_val   = launch_rd ? CW'(RD_CYC - 1) : CW'(WR_CYC - 1);
   assign cap_lanes = (state == ST_READ) ? ~lane_n : '0;

   sram_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire)
   );

   sram_turn_guard #(.TA_CYC(TA_CYC), .CW(CW)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (rd_end),
      .drive_ok (turn_ok)
   );

   sram_lane_data #(.LANE_W(LANE_W), .LANES(LANES)) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_load   (accept && req_write),
      .wr_data   (req_wdata),
      .cap       (rd_end || null_rd),
      .cap_lanes (cap_lanes),
      .dq_in     (mem_dq_in),
      .dq_out    (mem_dq_out),
      .rd_data   (rsp_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         pend_be    <= '0;
         lane_n     <= '1;
         mem_addr   <= '0;
         mem_cs_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_dq_oe  <= 1'b0;
         rsp_rvalid <= 1'b0;
         rsp_wdone  <= 1'b0;
      end else begin
         rsp_rvalid <= 1'b0;
         rsp_wdone  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  mem_addr <= req_addr;
                  pend_be  <= req_be;
                  if (!be_any) begin
                     rsp_rvalid <= !req_write;
                     rsp_wdone  <= req_write;
                  end else if (!req_write) begin
                     state    <= ST_READ;
                     mem_cs_n <= 1'b0;
                     mem_oe_n <= 1'b0;
                     lane_n   <= ~req_be;
                  end else if (turn_ok) begin
                     state     <= ST_WRITE;
                     mem_cs_n  <= 1'b0;
                     mem_we_n  <= 1'b0;
                     lane_n    <= ~req_be;
                     mem_dq_oe <= 1'b1;
                  end else begin
                     state <= ST_TURN;
                  end
               end
            end
            ST_TURN: begin
               if (turn_ok) begin
                  state     <= ST_WRITE;
                  mem_cs_n  <= 1'b0;
                  mem_we_n  <= 1'b0;
                  lane_n    <= ~pend_be;
                  mem_dq_oe <= 1'b1;
               end
            end
            ST_READ: begin
               if (rd_end) begin
                  state      <= ST_IDLE;
                  mem_cs_n   <= 1'b1;
                  mem_oe_n   <= 1'b1;
                  lane_n     <= '1;
                  rsp_rvalid <= 1'b1;
               end
            end
            ST_WRITE: begin
               if (wr_end) begin
                  state    <= ST_HOLD;
                  mem_cs_n <= 1'b1;
                  mem_we_n <= 1'b1;
                  lane_n   <= '1;
               end
            end
            ST_HOLD: begin
               state     <= ST_IDLE;
               mem_dq_oe <= 1'b0;
               rsp_wdone <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_lb_n = lane_n[0];
   assign mem_ub_n = lane_n[1];

   // run-length monitors feeding the assertions below
   logic [CW-1:0] we_run, oe_run, quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run <= '0;
         oe_run <= '0;
         quiet  <= CW'(TA_CYC);
      end else begin
         we_run <= mem_we_n ? '0 : we_run + 1'b1;
         oe_run <= mem_oe_n ? '0 : oe_run + 1'b1;
         if (!mem_oe_n)
            quiet <= '0;
         else if (!mem_dq_oe && quiet < CW'(TA_CYC))
            quiet <= quiet + 1'b1;
      end
   end

   AST_WE_HIGH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> mem_we_n);  // R3
   AST_RD_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_oe_n && oe_run != '0) |-> oe_run == CW'(RD_CYC));  // R2
   AST_WR_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_n && we_run != '0) |-> we_run == CW'(WR_CYC));  // R4
   AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && mem_dq_oe));  // R4
   AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> ($stable(mem_dq_out) && $stable(mem_addr)));  // R5
   AST_NO_DRIVE_INTO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);  // R6
   AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> quiet == CW'(TA_CYC));  // R6
   AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_rvalid, rsp_wdone}));  // R9
   AST_NULL_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !be_any) |=> mem_cs_n);  // R8
endmodule

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int CLK_PS = 4000;
   localparam int T_RC = 70000, T_AA = 70000, T_ACS = 70000, T_OE = 40000, T_BA = 40000;
   localparam int T_WC = 70000, T_WP = 55000, T_CW = 60000, T_DW = 35000, T_HZ = 30000;

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
   function automatic int cyc(input int ps);
      int c;
      c = (ps + CLK_PS - 1) / CLK_PS;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int RD = cyc(mx(mx(T_RC, T_AA), mx(mx(T_ACS, T_OE), T_BA)));
   localparam int WR = cyc(mx(mx(T_WC, T_WP), mx(T_CW, T_DW)));
   localparam int TA = cyc(T_HZ);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0] req_be = '0;
   logic req_ready, rsp_rvalid, rsp_wdone;
   logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;
   logic mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;

   always #2 clk = ~clk;

   sram_lane_ctrl #(
      .ADDR_W(AW), .LANE_W(8), .LANES(2), .CLK_PS(CLK_PS),
      .T_RC_PS(T_RC), .T_AA_PS(T_AA), .T_ACS_PS(T_ACS), .T_OE_PS(T_OE), .T_BA_PS(T_BA),
      .T_WC_PS(T_WC), .T_WP_PS(T_WP), .T_CW_PS(T_CW), .T_DW_PS(T_DW), .T_HZ_PS(T_HZ)
   ) u_sram_lane_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .rsp_wdone(rsp_wdone),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int checks = 0;
   int errors = 0;
   int proto_errs = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic proto_fail(input string tag, input longint act, input longint exp);
      proto_errs++;
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
   endtask

   // ---------------- memory model ----------------
   logic [DW-1:0] mdl [16];
   int rd_age, we_low, quiet;
   logic pend;
   logic [DW-1:0] pend_d;
   logic [1:0] pend_l;
   logic [AW-1:0] pend_a;
   logic prev_oe_drv;
   logic [DW-1:0] prev_dq;
   logic [AW-1:0] prev_addr;

   always_comb begin
      logic [DW-1:0] w;
      w = mdl[mem_addr];
      mem_dq_in = ~w;
      if (!mem_cs_n && !mem_oe_n && rd_age >= RD) begin
         if (!mem_lb_n) mem_dq_in[7:0]  = w[7:0];
         if (!mem_ub_n) mem_dq_in[15:8] = w[15:8];
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mdl[i] <= '0;
         rd_age <= 0; we_low <= 0; quiet <= 1000; pend <= 1'b0;
         prev_oe_drv <= 1'b0; prev_dq <= '0; prev_addr <= '0;
      end else begin
         if (!mem_cs_n && !mem_oe_n) rd_age <= rd_age + 1; else rd_age <= 0;
         if (!mem_oe_n && !mem_we_n) proto_fail("R3 we low during read", 0, 1);
         if (mem_dq_oe && !mem_oe_n) proto_fail("R6 drive while output enabled", 1, 0);
         if (mem_dq_oe && !prev_oe_drv && quiet < TA) proto_fail("R6 float gap", quiet, TA);
         if (!mem_oe_n) quiet <= 0;
         else if (!mem_dq_oe) quiet <= quiet + 1;
         if (mem_dq_oe && prev_oe_drv && (mem_dq_out != prev_dq || mem_addr != prev_addr))
            proto_fail("R5 data or address moved", mem_dq_out, prev_dq);
         if (!mem_we_n && !mem_oe_n == 1'b0 && !mem_cs_n) begin
            we_low <= we_low + 1;
            pend   <= 1'b1;
            pend_d <= mem_dq_out;
            pend_a <= mem_addr;
            pend_l <= {!mem_ub_n, !mem_lb_n};
         end else begin
            if (we_low != 0 && we_low != WR) proto_fail("R4 write pulse clocks", we_low, WR);
            we_low <= 0;
            if (pend) begin
               if (pend_l[0]) mdl[pend_a][7:0]  <= pend_d[7:0];
               if (pend_l[1]) mdl[pend_a][15:8] <= pend_d[15:8];
               pend <= 1'b0;
            end
         end
         prev_oe_drv <= mem_dq_oe;
         prev_dq     <= mem_dq_out;
         prev_addr   <= mem_addr;
      end
   end

   // ---------------- host side ----------------
   longint last_rd_ns = -100000;
   logic [DW-1:0] exp_mem [16];

   task automatic do_req(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] be, output int lat, output logic [DW-1:0] rd,
                         output bit cs_seen, output bit busy_ready, output longint t_drive);
      t_drive    = $time;
      cs_seen    = 1'b0;
      busy_ready = 1'b0;
      req_write  = w;
      req_addr   = a;
      req_wdata  = d;
      req_be     = be;
      req_valid  = 1'b1;
      lat = 0;
      rd  = '0;
      while (lat < 400) begin
         @(negedge clk);
         lat++;
         if (lat == 1) req_valid = 1'b0;
         if (!mem_cs_n) cs_seen = 1'b1;
         if (lat == 2) busy_ready = req_ready;
         if (rsp_rvalid || rsp_wdone) break;
      end
      rd = rsp_rdata;
   endtask

   function automatic logic [DW-1:0] lane_mask(input logic [1:0] be);
      return {{8{be[1]}}, {8{be[0]}}};
   endfunction

   task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
      int lat, exp_lat, gap;
      logic [DW-1:0] rd;
      bit cs_seen, busy;
      longint td;
      do_req(1'b1, a, d, be, lat, rd, cs_seen, busy, td);
      if (be == 2'b00) begin
         check(lat == 1, "R8 null write latency", lat, 1);
         check(!cs_seen, "R8 null write chip select", cs_seen, 0);
      end else begin
         gap = int'((last_rd_ns - td) / 4) + TA;
         exp_lat = mx(1, gap) + WR + 1;
         check(lat == exp_lat, "R4 R6 write latency", lat, exp_lat);
         check(!busy, "R9 ready low during write", busy, 0);
         exp_mem[a] = (exp_mem[a] & ~lane_mask(be)) | (d & lane_mask(be));
      end
   endtask

   task automatic host_read(input logic [AW-1:0] a, input logic [1:0] be);
      int lat;
      logic [DW-1:0] rd, exp_d;
      bit cs_seen, busy;
      longint td;
      do_req(1'b0, a, '0, be, lat, rd, cs_seen, busy, td);
      exp_d = exp_mem[a] & lane_mask(be);
      if (be == 2'b00) begin
         check(lat == 1, "R8 null read latency", lat, 1);
         check(!cs_seen && rd == '0, "R8 null read data/select", rd, 0);
      end else begin
         last_rd_ns = $time;
         check(lat == RD + 1, "R2 read latency", lat, RD + 1);
         check(!busy, "R9 ready low during read", busy, 0);
         check(rd == exp_d, "R7 read data by lane", rd, exp_d);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) exp_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(mem_cs_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe
            && req_ready && !rsp_rvalid && !rsp_wdone, "R1 reset state",
            {mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ready},
            7'b1111101);
      // fill all words with full-width writes
      for (int a = 0; a < 16; a++)
         host_write(a[AW-1:0], 16'hA5C3 ^ 16'(a * 16'h1111), 2'b11);
      // each byte-enable pattern, each written word read back whole (R7)
      for (int a = 0; a < 16; a++) begin
         for (int be = 0; be < 4; be++) begin
            host_write(a[AW-1:0], 16'(16'h9E37 * (a * 4 + be + 1)), be[1:0]);
            host_read(a[AW-1:0], 2'b11);
         end
      end
      // partial and null reads at every address
      for (int a = 0; a < 16; a++)
         for (int be = 0; be < 4; be++)
            host_read(a[AW-1:0], be[1:0]);
      // write straight after a partial read: turnaround gap (R6)
      host_read(4'd5, 2'b01);
      host_write(4'd5, 16'h1234, 2'b10);
      host_read(4'd5, 2'b11);
      repeat (4) @(negedge clk);
      check(proto_errs == 0, "R3 R4 R5 R6 protocol monitor", proto_errs, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule